// File: doc/BRIEF.md
# Paired-byte register write decoder

This block decodes write transactions arriving from a serial slave byte layer and turns them into commit strobes for a bank of 21 one-time-programmable configuration registers. The byte layer reports bus start and stop conditions and hands over each received byte with a one-cycle strobe. The decoder answers every byte with an acknowledge decision in the same cycle. When a complete data pair has arrived, it emits a one-cycle commit that carries the register index and a 10-bit value.

A transaction opens with a device address byte whose direction bit is low. A register index byte follows, and then one or more data pairs, each sent upper byte first. The upper byte carries a fixed marker in its top two bits and the two most significant value bits. The lower byte carries the remaining eight bits. After each committed pair the index steps forward by one, so a burst fills consecutive registers. The highest index holds a single write-lock flag. A burst never reaches it by stepping: it must be named directly in the index byte.

Top module: `pbw_engine`

## Requirements
- R1: The first byte after a start is acknowledged only when bits 7:1 equal the DEV_ADDR parameter and bit 0 (direction) is 0. Otherwise it is not acknowledged, and every byte up to the next start is not acknowledged and causes no commit.
- R2: The index byte is acknowledged only when bits 7:5 are zero and bits 4:0 are at most 20. Otherwise it is not acknowledged, and every later byte up to the next start is not acknowledged and causes no commit.
- R3: An upper data byte is acknowledged only when bits 7:6 equal binary 01. A rejected upper byte causes no commit, and the next byte is again treated as an upper byte.
- R4: In the cycle after an accepted lower byte, commit_vld is high for one cycle. commit_idx holds the current index and commit_val holds {upper[1:0], lower[7:0]}.
- R5: A stop or a start that arrives after an accepted upper byte but before its lower byte discards the pair, and no commit follows.
- R6: After each commit the index advances by one, so successive pairs target consecutive registers.
- R7: Once a burst has committed index 19, further upper bytes in that transaction are not acknowledged and cause no commit.
- R8: Index 20 accepts a pair only when the index byte named it directly. Its commit value is lower[0] with bits 9:1 zero. After that commit, further upper bytes are not acknowledged.
- R9: ack is low whenever byte_vld is low. After reset, no byte is acknowledged before a start and commit_vld stays low.
- R10: A lower byte that follows an accepted upper byte is always acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle pulse on a start or repeated start condition |
| bus_stop | input | 1 | One-cycle pulse on a stop condition |
| byte_vld | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| ack | output | 1 | Acknowledge decision for the byte strobed this cycle |
| commit_vld | output | 1 | One-cycle register write strobe |
| commit_idx | output | 5 | Register index of the write |
| commit_val | output | 10 | Value to write |

## Verification
The assertions assume that the byte layer never strobes a byte in the same cycle as a start or stop pulse. They also assume that a start and a stop never coincide. If either happens, control events take priority by design, but the properties about commit timing would no longer be meaningful. The bench drives each event on its own falling edge and releases it one cycle later, so every byte, start and stop occupies a separate cycle. The sweeps cover all 256 address bytes, all 256 index bytes and all 256 upper-byte patterns, plus every burst start point from 0 to 19.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    localparam int IDX_W     = 5;
    localparam int VAL_W     = 10;
    localparam int NUM_REGS  = 21;
    localparam int HI_BITS   = VAL_W - 8;
    localparam int ZERO_TOP  = 8 - IDX_W;

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] LAST_AUTO = IDX_W'(NUM_REGS - 2);
    localparam logic [1:0]       HI_MARK   = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_IDX,
        ST_HI,
        ST_LO
    } pbw_state_e;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] val;
    } pbw_commit_t;

    function automatic logic marker_ok(input logic [7:0] b);
        return b[7:6] == HI_MARK;
    endfunction

    function automatic logic [VAL_W-1:0] build_value(
        input logic [HI_BITS-1:0] hi,
        input logic [7:0]         lo,
        input logic               lock_slot
    );
        if (lock_slot)
            return {{(VAL_W-1){1'b0}}, lo[0]};
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pbw_addr_match.sv
module pbw_addr_match #(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic [7:0] byte_data,
    output logic       hit
);
    always_comb begin
        hit = (byte_data[7:1] == DEV_ADDR) && (byte_data[0] == 1'b0);
    end
endmodule

// File: rtl/pbw_index_gate.sv
module pbw_index_gate
    import pbw_pkg::*;
(
    input  logic [7:0]       byte_data,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             stepped,
    output logic             idx_ok,
    output logic             slot_open
);
    always_comb begin
        idx_ok    = (byte_data[7:IDX_W] == '0) &&
                    (byte_data[IDX_W-1:0] <= LAST_IDX);
        slot_open = (cur_idx <= LAST_AUTO) ||
                    ((cur_idx == LAST_IDX) && !stepped);
    end
endmodule

// File: rtl/pbw_pair_reg.sv
module pbw_pair_reg
    import pbw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_hi,
    input  logic               fire,
    input  logic [7:0]         byte_data,
    input  logic [IDX_W-1:0]   cur_idx,
    output pbw_commit_t        commit
);
    logic [HI_BITS-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            commit <= '0;
        end else begin
            if (load_hi)
                hi_q <= byte_data[HI_BITS-1:0];
            commit.vld <= fire;
            if (fire) begin
                commit.idx <= cur_idx;
                commit.val <= build_value(hi_q, byte_data, cur_idx == LAST_IDX);
            end
        end
    end

    AST_FIRE_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(fire && load_hi)); // R4
endmodule

// File: rtl/pbw_engine.sv
module pbw_engine
    import pbw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             ack,
    output logic             commit_vld,
    output logic [IDX_W-1:0] commit_idx,
    output logic [VAL_W-1:0] commit_val
);
    pbw_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             stepped_q;
    logic             addr_hit, idx_ok, slot_open;
    logic             ctrl, take, load_hi, fire;
    pbw_commit_t      commit;

    pbw_addr_match #(.DEV_ADDR(DEV_ADDR)) u_addr (
        .byte_data (byte_data),
        .hit       (addr_hit)
    );

    pbw_index_gate u_gate (
        .byte_data (byte_data),
        .cur_idx   (idx_q),
        .stepped   (stepped_q),
        .idx_ok    (idx_ok),
        .slot_open (slot_open)
    );

    always_comb begin
        ctrl = bus_start || bus_stop;
        take = byte_vld && !ctrl;
        unique case (state_q)
            ST_DEV:  ack = take && addr_hit;
            ST_IDX:  ack = take && idx_ok;
            ST_HI:   ack = take && marker_ok(byte_data) && slot_open;
            ST_LO:   ack = take;
            default: ack = 1'b0;
        endcase
        load_hi = (state_q == ST_HI) && ack;
        fire    = (state_q == ST_LO) && take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            stepped_q <= 1'b0;
        end else if (bus_start) begin
            state_q   <= ST_DEV;
            stepped_q <= 1'b0;
        end else if (bus_stop) begin
            state_q   <= ST_IDLE;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_DEV: state_q <= addr_hit ? ST_IDX : ST_IDLE;
                ST_IDX: begin
                    if (idx_ok) begin
                        idx_q     <= byte_data[IDX_W-1:0];
                        stepped_q <= 1'b0;
                        state_q   <= ST_HI;
                    end else begin
                        state_q   <= ST_IDLE;
                    end
                end
                ST_HI: if (load_hi) state_q <= ST_LO;
                ST_LO: begin
                    idx_q     <= idx_q + 1'b1;
                    stepped_q <= 1'b1;
                    state_q   <= ST_HI;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    pbw_pair_reg u_pair (
        .clk       (clk),
        .rst       (rst),
        .load_hi   (load_hi),
        .fire      (fire),
        .byte_data (byte_data),
        .cur_idx   (idx_q),
        .commit    (commit)
    );

    assign commit_vld = commit.vld;
    assign commit_idx = commit.idx;
    assign commit_val = commit.val;

    AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> !ack); // R9
    AST_COMMIT_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> $past(byte_vld && ack)); // R4
    AST_COMMIT_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> (commit_idx <= LAST_IDX)); // R2
    AST_LOCK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (commit_vld && commit_idx == LAST_IDX) |-> (commit_val[VAL_W-1:1] == '0)); // R8
    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !commit_vld); // R5
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        commit_vld |=> !commit_vld); // R4
endmodule

// File: tb/test_pbw_engine.sv
module test_pbw_engine;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       ack;
    logic       commit_vld;
    logic [4:0] commit_idx;
    logic [9:0] commit_val;

    localparam logic [6:0] DEV = 7'h2C;
    localparam logic [7:0] WR_BYTE = {DEV, 1'b0};

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pbw_engine #(.DEV_ADDR(DEV)) i_pbw_engine (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_vld(byte_vld), .byte_data(byte_data), .ack(ack),
        .commit_vld(commit_vld), .commit_idx(commit_idx), .commit_val(commit_val)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input bit exp_ack, input string req);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = d;
        #1;
        chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic exp_commit(input bit v, input int idx, input int val, input string req);
        chk(commit_vld == v, req, int'(commit_vld), int'(v));
        if (v && commit_vld) begin
            chk(int'(commit_idx) == idx, req, int'(commit_idx), idx);
            chk(int'(commit_val) == val, req, int'(commit_val), val);
        end
    endtask

    task automatic do_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic open_at(input logic [7:0] idx);
        do_start();
        put_byte(WR_BYTE, 1'b1, "R1");
        put_byte(idx, 1'b1, "R2");
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9: reset state and idle before any start
        #1;
        chk(ack == 1'b0, "R9 ack after reset", int'(ack), 0);
        chk(commit_vld == 1'b0, "R9 commit after reset", int'(commit_vld), 0);
        put_byte(WR_BYTE, 1'b0, "R9 byte before start");
        exp_commit(1'b0, 0, 0, "R9");

        // R1: sweep every address byte
        for (int b = 0; b < 256; b++) begin
            bit hit;
            hit = (b[7:0] == WR_BYTE);
            do_start();
            put_byte(b[7:0], hit, "R1 address sweep");
            put_byte(8'h00, hit, "R1 follow-up after address");
            put_byte(8'h41, hit, "R1 upper after address");
            put_byte(8'h22, hit, "R1 lower after address");
            exp_commit(hit, 0, 10'h122, "R1 commit after address");
            do_stop();
        end

        // R2 / R4 / R8: sweep every index byte
        for (int i = 0; i < 256; i++) begin
            bit ok;
            ok = (i < 21);
            do_start();
            put_byte(WR_BYTE, 1'b1, "R1");
            put_byte(i[7:0], ok, "R2 index sweep");
            put_byte(8'h41, ok, "R2 upper after index");
            exp_commit(1'b0, 0, 0, "R2");
            put_byte(8'h5B, ok, "R10 lower after index");
            exp_commit(ok, i, (i == 20) ? 1 : 10'h15B, (i == 20) ? "R8 lock value" : "R4 commit value");
            if (i == 20)
                put_byte(8'h41, 1'b0, "R8 no pair after lock slot");
            do_stop();
        end

        // R3: sweep every upper byte pattern
        for (int p = 0; p < 256; p++) begin
            bit ok;
            ok = (p[7:6] == 2'b01);
            open_at(8'd3);
            put_byte(p[7:0], ok, "R3 marker sweep");
            exp_commit(1'b0, 0, 0, "R3 no commit on upper");
            if (ok) begin
                put_byte(8'hC3, 1'b1, "R10 lower ack");
                exp_commit(1'b1, 3, {p[1:0], 8'hC3}, "R4 value from pair");
            end else begin
                put_byte(8'h42, 1'b1, "R3 retry upper");
                put_byte(8'h10, 1'b1, "R10 lower ack");
                exp_commit(1'b1, 3, 10'h210, "R3 retry commit");
            end
            do_stop();
        end

        // R6 / R7: bursts from every start point
        for (int s = 0; s < 20; s++) begin
            open_at(s[7:0]);
            for (int k = s; k < 20; k++) begin
                logic [9:0] v;
                v = 10'((k * 37 + s * 11) % 1024);
                put_byte({2'b01, 4'b0000, v[9:8]}, 1'b1, "R6 burst upper");
                put_byte(v[7:0], 1'b1, "R6 burst lower");
                exp_commit(1'b1, k, int'(v), "R6 burst commit");
            end
            put_byte(8'h41, 1'b0, "R7 past last auto index");
            exp_commit(1'b0, 0, 0, "R7 no commit");
            put_byte(8'h55, 1'b0, "R7 still refused");
            exp_commit(1'b0, 0, 0, "R7 no commit");
            do_stop();
        end

        // R5: stop after upper byte
        open_at(8'd5);
        put_byte(8'h41, 1'b1, "R3");
        do_stop();
        exp_commit(1'b0, 0, 0, "R5 stop discards pair");
        // R5: repeated start after upper byte
        open_at(8'd5);
        put_byte(8'h41, 1'b1, "R3");
        do_start();
        exp_commit(1'b0, 0, 0, "R5 restart discards pair");
        put_byte(WR_BYTE, 1'b1, "R1 after restart");
        put_byte(8'd5, 1'b1, "R2");
        put_byte(8'h43, 1'b1, "R3");
        put_byte(8'h00, 1'b1, "R10");
        exp_commit(1'b1, 5, 10'h300, "R5 new transaction commits");
        do_stop();

        // R8: lock slot keeps only bit 0
        open_at(8'd20);
        put_byte(8'h43, 1'b1, "R8 lock upper");
        put_byte(8'hFE, 1'b1, "R10");
        exp_commit(1'b1, 20, 0, "R8 lock bit only");
        do_stop();

        // R2: bad index ignores rest of transaction
        do_start();
        put_byte(WR_BYTE, 1'b1, "R1");
        put_byte(8'h25, 1'b0, "R2 high bits set");
        put_byte(8'h41, 1'b0, "R2 ignored upper");
        put_byte(8'h00, 1'b0, "R2 ignored lower");
        exp_commit(1'b0, 0, 0, "R2 no commit");
        do_stop();

        finish_run();
    end
endmodule